// File: doc/BRIEF.md
# SPI FIFO Level, Status and Interrupt Unit

This unit sits between the register interface and the serial engine of an SPI controller. It holds the transmit and receive queues, whose depth is fixed when the design is elaborated (32 or 64 words). It keeps a count of the words in each queue and derives full and empty flags from those counts. It records overflow and underflow events as sticky flags. Its interrupt status comes in two forms, raw and masked, and it drives one combined interrupt line. It also raises a transmit and a receive DMA request from watermarks that software programs.

The register side pushes transmit words and pops receive words. The serial engine pops transmit words and pushes receive words. A small controller state machine follows the enable input and the engine's activity and reports a busy bit. Its states are OFF, IDLE and BUSY. The transitions are:
- OFF to IDLE when enabled with nothing to do.
- OFF to BUSY when enabled with work pending.
- IDLE to BUSY when the transmit queue holds data or the engine is shifting.
- BUSY to IDLE when both of those end.
- Any state to OFF when the enable drops.

While the unit is disabled, both queues are flushed.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: After reset the following hold. Both levels are 0. The status word is 5'b01100; its bit order is bit0 busy, bit1 tx full, bit2 tx empty, bit3 rx empty, bit4 rx full. The raw interrupt word is 5'b00001. The masked word, the interrupt line and both DMA requests are 0.
- R2: Each queue returns words in the order they were pushed. Its level counts accepted words from 0 up to DEPTH, and the full status bit is set when the level reaches DEPTH.
- R3: While en_i is low, both queues are emptied at the next clock edge. Pushes are ignored and set no overflow flag.
- R4: A push to a full queue leaves its level and contents unchanged. It sets the sticky overflow bit in the raw interrupt word: bit1 for tx, bit3 for rx.
- R5: A pop from an empty receive queue while enabled sets the sticky receive-underflow bit, which is raw bit2.
- R6: Raw bit4 (receive level) is 1 exactly when the rx level is strictly greater than the receive threshold (register select 0).
- R7: The masked word equals the raw word AND the mask (register select 3). irq_o is the OR of the masked bits.
- R8: A write to the clear command (register select 5) clears sticky flags as follows: data bit0 clears all three, bit1 clears rx underflow, bit2 clears rx overflow, bit3 clears tx overflow. Flags not named are kept.
- R9: The DMA control register (select 4) enables the tx request with bit1 and the rx request with bit0. The tx request is high while the tx level is at or below the tx watermark (select 1). The rx request is high while the rx level is above the rx watermark (select 2).
- R10: Writes to selects 0, 1 and 2 are ignored while en_i is high. Writes to selects 3, 4 and 5 take effect at any time.
- R11: Status bit0 (busy) is 1 only in state BUSY. The state is updated one edge after its inputs: enable, tx queue non-empty, engine active.
- R12: Raw bit0 is 1 exactly when the tx level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Controller enable; low flushes the queues |
| eng_active_i | input | 1 | Serial engine is shifting a word |
| tx_push_i | input | 1 | Register side writes a transmit word |
| tx_wdata_i | input | WIDTH | Transmit word to store |
| tx_pop_i | input | 1 | Engine takes a transmit word |
| tx_rdata_o | output | WIDTH | Oldest transmit word |
| rx_push_i | input | 1 | Engine delivers a received word |
| rx_wdata_i | input | WIDTH | Received word to store |
| rx_pop_i | input | 1 | Register side reads a receive word |
| rx_rdata_o | output | WIDTH | Oldest receive word |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration register select |
| cfg_wdata_i | input | LVL_W | Configuration write data |
| tx_level_o | output | LVL_W | Transmit queue level |
| rx_level_o | output | LVL_W | Receive queue level |
| status_o | output | 5 | Status word |
| raw_int_o | output | 5 | Raw interrupt word |
| int_stat_o | output | 5 | Masked interrupt word |
| irq_o | output | 1 | Combined interrupt |
| tx_dma_req_o | output | 1 | Transmit DMA request |
| rx_dma_req_o | output | 1 | Receive DMA request |

## Verification
Corrupt queue pointers or counts show up on the level outputs one edge after the push or pop that caused them. The reordered data then appears when the scoreboard drains the receive queue. A stuck or lost sticky flag shows on the raw interrupt word one edge after the overflowing push or the clear command. A wrong threshold register shows when the receive-level bit or a DMA request switches on the wrong level. A wrong controller state shows on the busy bit within two edges of a transmit push or an engine-activity change.

// File: rtl/spi_fis_pkg.sv
package spi_fis_pkg;

    typedef enum logic [2:0] {
        SEL_RX_THR  = 3'd0,
        SEL_TX_WMK  = 3'd1,
        SEL_RX_WMK  = 3'd2,
        SEL_MASK    = 3'd3,
        SEL_DMA_CTL = 3'd4,
        SEL_CLEAR   = 3'd5
    } cfg_sel_e;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_BUSY = 2'd2
    } ctl_state_e;

    localparam int INT_W = 5;

endpackage

// File: rtl/spi_fifo_buf.sv
module spi_fifo_buf #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             push_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic [LVL_W-1:0] level_o,
    output logic             full_o,
    output logic             empty_o
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [LVL_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign full_o  = (cnt_q == LVL_W'(DEPTH));
    assign empty_o = (cnt_q == '0);
    assign do_push = push_i && !flush_i && !full_o;
    assign do_pop  = pop_i && !flush_i && !empty_o;
    assign rdata_o = mem[rd_ptr_q];
    assign level_o = cnt_q;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr_q] <= wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else if (flush_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (do_push) wr_ptr_q <= wr_ptr_q + PTR_W'(1);
            if (do_pop)  rd_ptr_q <= rd_ptr_q + PTR_W'(1);
            if (do_push && !do_pop)      cnt_q <= cnt_q + LVL_W'(1);
            else if (do_pop && !do_push) cnt_q <= cnt_q - LVL_W'(1);
        end
    end

endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
    import spi_fis_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             cfg_we_i,
    input  logic [2:0]       cfg_sel_i,
    input  logic [LVL_W-1:0] cfg_wdata_i,
    input  logic             tx_push_i,
    input  logic             rx_push_i,
    input  logic             rx_pop_i,
    input  logic             tx_full_i,
    input  logic             rx_full_i,
    input  logic             rx_empty_i,
    input  logic [LVL_W-1:0] tx_level_i,
    input  logic [LVL_W-1:0] rx_level_i,
    output logic [INT_W-1:0] raw_int_o,
    output logic [INT_W-1:0] int_stat_o,
    output logic             irq_o,
    output logic             tx_dma_req_o,
    output logic             rx_dma_req_o
);

    logic [LVL_W-1:0] rx_thr_q, tx_wmk_q, rx_wmk_q;
    logic [INT_W-1:0] mask_q;
    logic [1:0]       dma_ctl_q;
    logic             tx_ovf_q, rx_ovf_q, rx_unf_q;
    logic             thr_wr_ok, clr_hit;

    assign thr_wr_ok = cfg_we_i && !en_i;
    assign clr_hit   = cfg_we_i && (cfg_sel_i == SEL_CLEAR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_thr_q  <= '0;
            tx_wmk_q  <= '0;
            rx_wmk_q  <= '0;
            mask_q    <= '0;
            dma_ctl_q <= '0;
        end else begin
            if (thr_wr_ok && cfg_sel_i == SEL_RX_THR) rx_thr_q <= cfg_wdata_i;
            if (thr_wr_ok && cfg_sel_i == SEL_TX_WMK) tx_wmk_q <= cfg_wdata_i;
            if (thr_wr_ok && cfg_sel_i == SEL_RX_WMK) rx_wmk_q <= cfg_wdata_i;
            if (cfg_we_i && cfg_sel_i == SEL_MASK)    mask_q    <= cfg_wdata_i[INT_W-1:0];
            if (cfg_we_i && cfg_sel_i == SEL_DMA_CTL) dma_ctl_q <= cfg_wdata_i[1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_ovf_q <= 1'b0;
            rx_ovf_q <= 1'b0;
            rx_unf_q <= 1'b0;
        end else begin
            tx_ovf_q <= (tx_ovf_q && !(clr_hit && (cfg_wdata_i[0] || cfg_wdata_i[3])))
                        || (en_i && tx_push_i && tx_full_i);
            rx_ovf_q <= (rx_ovf_q && !(clr_hit && (cfg_wdata_i[0] || cfg_wdata_i[2])))
                        || (en_i && rx_push_i && rx_full_i);
            rx_unf_q <= (rx_unf_q && !(clr_hit && (cfg_wdata_i[0] || cfg_wdata_i[1])))
                        || (en_i && rx_pop_i && rx_empty_i);
        end
    end

    assign raw_int_o    = {(rx_level_i > rx_thr_q), rx_ovf_q, rx_unf_q, tx_ovf_q,
                           (tx_level_i == '0)};
    assign int_stat_o   = raw_int_o & mask_q;
    assign irq_o        = |int_stat_o;
    assign tx_dma_req_o = dma_ctl_q[1] && (tx_level_i <= tx_wmk_q);
    assign rx_dma_req_o = dma_ctl_q[0] && (rx_level_i > rx_wmk_q);

endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
    import spi_fis_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int WIDTH = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             eng_active_i,
    input  logic             tx_push_i,
    input  logic [WIDTH-1:0] tx_wdata_i,
    input  logic             tx_pop_i,
    output logic [WIDTH-1:0] tx_rdata_o,
    input  logic             rx_push_i,
    input  logic [WIDTH-1:0] rx_wdata_i,
    input  logic             rx_pop_i,
    output logic [WIDTH-1:0] rx_rdata_o,
    input  logic             cfg_we_i,
    input  logic [2:0]       cfg_sel_i,
    input  logic [LVL_W-1:0] cfg_wdata_i,
    output logic [LVL_W-1:0] tx_level_o,
    output logic [LVL_W-1:0] rx_level_o,
    output logic [4:0]       status_o,
    output logic [4:0]       raw_int_o,
    output logic [4:0]       int_stat_o,
    output logic             irq_o,
    output logic             tx_dma_req_o,
    output logic             rx_dma_req_o
);

    logic       flush;
    logic       tx_full, tx_empty, rx_full, rx_empty;
    logic       work, busy;
    ctl_state_e state_q, state_d;

    assign flush = !en_i;

    spi_fifo_buf #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush_i(flush),
        .push_i(tx_push_i), .wdata_i(tx_wdata_i), .pop_i(tx_pop_i),
        .rdata_o(tx_rdata_o), .level_o(tx_level_o),
        .full_o(tx_full), .empty_o(tx_empty)
    );

    spi_fifo_buf #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush_i(flush),
        .push_i(rx_push_i), .wdata_i(rx_wdata_i), .pop_i(rx_pop_i),
        .rdata_o(rx_rdata_o), .level_o(rx_level_o),
        .full_o(rx_full), .empty_o(rx_empty)
    );

    spi_irq_ctrl #(.LVL_W(LVL_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .en_i(en_i),
        .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i),
        .tx_push_i(tx_push_i), .rx_push_i(rx_push_i), .rx_pop_i(rx_pop_i),
        .tx_full_i(tx_full), .rx_full_i(rx_full), .rx_empty_i(rx_empty),
        .tx_level_i(tx_level_o), .rx_level_i(rx_level_o),
        .raw_int_o(raw_int_o), .int_stat_o(int_stat_o), .irq_o(irq_o),
        .tx_dma_req_o(tx_dma_req_o), .rx_dma_req_o(rx_dma_req_o)
    );

    assign work = !tx_empty || eng_active_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (en_i) state_d = work ? ST_BUSY : ST_IDLE;
            ST_IDLE: if (!en_i) state_d = ST_OFF;
                     else if (work) state_d = ST_BUSY;
            ST_BUSY: if (!en_i) state_d = ST_OFF;
                     else if (!work) state_d = ST_IDLE;
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        busy = (state_q == ST_BUSY);
    end

    assign status_o = {rx_full, rx_empty, tx_empty, tx_full, busy};

endmodule

// File: rtl/spi_fifo_irq_chk.sv
module spi_fifo_irq_chk #(
    parameter int DEPTH = 32,
    parameter int LVL_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_i,
    input logic             cfg_we_i,
    input logic [2:0]       cfg_sel_i,
    input logic             rx_push_i,
    input logic             rx_pop_i,
    input logic [LVL_W-1:0] tx_level_o,
    input logic [LVL_W-1:0] rx_level_o,
    input logic [4:0]       status_o,
    input logic [4:0]       raw_int_o,
    input logic [4:0]       int_stat_o
);

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level_o <= LVL_W'(DEPTH)) && (rx_level_o <= LVL_W'(DEPTH)));  // R2

    AST_RX_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && rx_push_i && !rx_pop_i && rx_level_o < LVL_W'(DEPTH))
        |=> rx_level_o == $past(rx_level_o) + LVL_W'(1));  // R2

    AST_FLUSH_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (tx_level_o == '0) && (rx_level_o == '0));  // R3

    AST_RX_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_int_o[3] && !(cfg_we_i && cfg_sel_i == 3'd5)) |=> raw_int_o[3]);  // R4

    AST_MASK_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (int_stat_o & ~raw_int_o) == 5'd0);  // R7

    AST_NOT_BUSY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !status_o[0]);  // R11

    AST_TX_FULL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_o[1] && status_o[2]));  // R2

endmodule

bind spi_fifo_irq_unit spi_fifo_irq_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en_i(en_i),
    .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
    .rx_push_i(rx_push_i), .rx_pop_i(rx_pop_i),
    .tx_level_o(tx_level_o), .rx_level_o(rx_level_o),
    .status_o(status_o), .raw_int_o(raw_int_o), .int_stat_o(int_stat_o)
);

// File: tb/spi_fifo_irq_unit_tb.sv
module spi_fifo_irq_unit_tb;

    localparam int DEPTH = 32;
    localparam int WIDTH = 16;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en_i = 1'b0, eng_active_i = 1'b0;
    logic             tx_push_i = 1'b0, tx_pop_i = 1'b0;
    logic             rx_push_i = 1'b0, rx_pop_i = 1'b0;
    logic [WIDTH-1:0] tx_wdata_i = '0, rx_wdata_i = '0;
    logic [WIDTH-1:0] tx_rdata_o, rx_rdata_o;
    logic             cfg_we_i = 1'b0;
    logic [2:0]       cfg_sel_i = '0;
    logic [LVL_W-1:0] cfg_wdata_i = '0;
    logic [LVL_W-1:0] tx_level_o, rx_level_o;
    logic [4:0]       status_o, raw_int_o, int_stat_o;
    logic             irq_o, tx_dma_req_o, rx_dma_req_o;

    int checks = 0;
    int fails  = 0;
    logic [WIDTH-1:0] rx_q [$];

    always #5 clk = ~clk;

    spi_fifo_irq_unit #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic push_rx(input logic [WIDTH-1:0] d, input bit expect_keep);
        rx_push_i = 1'b1; rx_wdata_i = d;
        tick();
        rx_push_i = 1'b0;
        if (expect_keep) rx_q.push_back(d);
    endtask

    // scoreboard monitor: compare the oldest word, then pop it
    task automatic pop_rx();
        if (rx_q.size() > 0) chk("R2 rx order", int'(rx_rdata_o), int'(rx_q.pop_front()));
        rx_pop_i = 1'b1;
        tick();
        rx_pop_i = 1'b0;
    endtask

    task automatic push_tx(input logic [WIDTH-1:0] d);
        tx_push_i = 1'b1; tx_wdata_i = d;
        tick();
        tx_push_i = 1'b0;
    endtask

    task automatic pop_tx();
        tx_pop_i = 1'b1;
        tick();
        tx_pop_i = 1'b0;
    endtask

    task automatic cfg(input logic [2:0] sel, input int val);
        cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = LVL_W'(val);
        tick();
        cfg_we_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 tx level", int'(tx_level_o), 0);
        chk("R1 rx level", int'(rx_level_o), 0);
        chk("R1 status", int'(status_o), 5'b01100);
        chk("R1 raw", int'(raw_int_o), 5'b00001);
        chk("R1 irq", int'(irq_o), 0);
        chk("R1 dma", int'({tx_dma_req_o, rx_dma_req_o}), 0);

        // R3 pushes ignored while disabled
        for (int i = 0; i < 3; i++) push_rx(WIDTH'(16'h0A00 + i), 1'b0);
        chk("R3 rx level off", int'(rx_level_o), 0);
        chk("R3 no ovf off", int'(raw_int_o), 5'b00001);
        cfg(3'd0, 3);
        cfg(3'd1, 4);
        cfg(3'd2, 2);

        // R11 controller states
        en_i = 1'b1;
        tick();
        chk("R11 idle", int'(status_o[0]), 0);
        push_tx(16'hAAAA);
        tick();
        chk("R11 busy tx", int'(status_o[0]), 1);
        pop_tx();
        tick();
        chk("R11 back idle", int'(status_o[0]), 0);
        eng_active_i = 1'b1;
        tick();
        chk("R11 busy engine", int'(status_o[0]), 1);
        eng_active_i = 1'b0;
        tick();
        chk("R11 engine done", int'(status_o[0]), 0);

        // R10 threshold write ignored while enabled; R6 strict compare
        cfg(3'd0, 10);
        push_rx(16'h1111, 1'b1);
        push_rx(16'h2222, 1'b1);
        push_rx(16'h3333, 1'b1);
        chk("R6 level eq thr", int'(raw_int_o), 5'b00001);
        push_rx(16'h4444, 1'b1);
        chk("R6 R10 level above thr", int'(raw_int_o), 5'b10001);

        // R7 masking
        cfg(3'd3, 5'h10);
        chk("R7 masked rxfull", int'(int_stat_o), 5'h10);
        chk("R7 irq on", int'(irq_o), 1);
        cfg(3'd3, 5'h08);
        chk("R7 masked none", int'(int_stat_o), 0);
        chk("R7 irq off", int'(irq_o), 0);

        // R9 DMA requests
        cfg(3'd4, 1);
        chk("R9 rx req", int'(rx_dma_req_o), 1);
        chk("R9 tx req disabled", int'(tx_dma_req_o), 0);
        cfg(3'd4, 3);
        chk("R9 tx req low level", int'(tx_dma_req_o), 1);
        for (int i = 0; i < 5; i++) push_tx(WIDTH'(16'hB000 + i));
        chk("R9 tx req above wmk", int'(tx_dma_req_o), 0);
        chk("R12 tx not empty", int'(raw_int_o[0]), 0);
        pop_tx();
        chk("R9 tx req at wmk", int'(tx_dma_req_o), 1);
        pop_rx();
        pop_rx();
        chk("R9 rx req at wmk", int'(rx_dma_req_o), 0);
        for (int i = 0; i < 4; i++) pop_tx();
        chk("R12 tx empty", int'(raw_int_o[0]), 1);
        cfg(3'd4, 0);

        // R2 fill to full; R4 overflow
        for (int i = 0; i < DEPTH - 2; i++) push_rx(WIDTH'(16'h0100 + i), 1'b1);
        chk("R2 rx level full", int'(rx_level_o), DEPTH);
        chk("R2 rx full status", int'(status_o[4]), 1);
        push_rx(16'hDEAD, 1'b0);
        chk("R4 rx level kept", int'(rx_level_o), DEPTH);
        chk("R4 rx ovf", int'(raw_int_o[3]), 1);
        for (int i = 0; i < DEPTH; i++) pop_rx();
        chk("R2 rx empty status", int'(status_o[3]), 1);
        pop_rx();
        chk("R5 rx underflow", int'(raw_int_o), 5'b01101);

        // R8 selective and global clear
        cfg(3'd5, 4);
        chk("R8 clear rx ovf only", int'(raw_int_o), 5'b00101);
        for (int i = 0; i < DEPTH + 1; i++) push_tx(WIDTH'(i));
        chk("R4 tx level kept", int'(tx_level_o), DEPTH);
        chk("R4 tx ovf", int'(raw_int_o), 5'b00110);
        cfg(3'd5, 1);
        chk("R8 clear all", int'(raw_int_o), 5'b00000);

        // R3 disable flushes; R11 off
        en_i = 1'b0;
        tick();
        chk("R3 tx flushed", int'(tx_level_o), 0);
        chk("R11 off not busy", int'(status_o[0]), 0);

        // R10 threshold write accepted while disabled
        cfg(3'd0, 10);
        en_i = 1'b1;
        rx_q.delete();
        for (int i = 0; i < 10; i++) push_rx(WIDTH'(i), 1'b1);
        chk("R10 new thr not hit", int'(raw_int_o[4]), 0);
        push_rx(16'h00FF, 1'b1);
        chk("R10 new thr hit", int'(raw_int_o[4]), 1);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule